// File: doc/BRIEF.md
# Trunk-Tagged Frame Inner Checksum Patcher

This block works on one Ethernet frame that already sits in a byte-addressable transmit buffer, before the frame leaves the buffer. A start pulse hands over the total byte length of the frame. The block then reads the first six bytes and compares them against the fixed multicast destination used for VLAN trunk encapsulation. If they match, it reads the outer type/length field. From that field it works out where the encapsulated inner frame lies and checks that it fits inside the buffered length.

When the frame qualifies, the block writes zero into destination byte 4. It then runs a CRC-32 over the inner payload, one byte per clock. Finally it writes the complemented result over the last four bytes of the frame, lowest byte first. Frames that fail any test are left untouched. Every accepted start ends with a one-cycle done pulse. The buffer is accessed through a plain port with combinational read data and a single-cycle write strobe.

Top module: `fcs_rewriter`

## Requirements
- R1: While reset is asserted and after its release with no start, done_o and buf_we_o are low.
- R2: The frame qualifies only if bytes 0 to 5 read 0x01, 0x00, 0x0C, 0x00, 0x10, 0x00 in that order. If any of them differs, no byte of the buffer is written and done_o still pulses.
- R3: For a qualifying frame that fits, byte 4 is overwritten with 0x00 and no other destination byte changes.
- R4: The inner payload begins at offset 14 + ENC_HDR. Its length is the 16-bit field at bytes 12 (high) and 13 (low), minus ENC_HDR, minus 4.
- R5: If that field is below ENC_HDR + 4, or the inner start plus inner length exceeds frame_len_i, the buffer is left unchanged.
- R6: The checksum is CRC-32 with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, one byte per cycle with the least significant bit first, and a bitwise complement at the end.
- R7: The checksum is written to bytes frame_len_i-4 to frame_len_i-1, least significant byte at the lowest address. Nothing outside bytes 4 and those four is written.
- R8: done_o is high for exactly one cycle per accepted start.
- R9: A start_i pulse that arrives while a frame is in progress is ignored. The frame in progress completes with its own length, and no extra done_o follows.
- R10: An inner length of zero is valid, and it stores the checksum 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin processing one frame (sampled when idle) |
| frame_len_i | input | LEN_W | Total frame length in bytes, sampled with start_i |
| buf_addr_o | output | LEN_W | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer read data, combinational from buf_addr_o |
| buf_we_o | output | 1 | Buffer byte write strobe |
| buf_wdata_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle pulse when the frame is finished |

## Verification
The bench builds the block with LEN_W = 9 and the default ENC_HDR = 26. The 9-bit length gives a 512-byte buffer, small enough to compare in full after every frame, so stray writes anywhere are caught. It also allows a 511-byte frame whose type field has a nonzero high byte and whose inner payload ends one byte short of the frame. With the 26-byte header the inner start sits at offset 40. Type values 29 and 30 then probe the underflow guard and the zero-length payload, and a type of 39 over the ASCII digits 1 to 9 reproduces the well-known CRC-32 check value.

// File: rtl/fcsrw_pkg.sv
package fcsrw_pkg;

  localparam int unsigned ETH_HDR_BYTES = 14;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  // byte 0 of the destination sits in the top octet
  localparam logic [47:0] TRUNK_DA = 48'h01_00_0C_00_10_00;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DA, ST_TYPE_HI, ST_TYPE_LO, ST_CHECK,
    ST_PATCH, ST_CRC, ST_FCS, ST_DONE
  } rw_state_e;

  function automatic logic [7:0] da_byte(input logic [2:0] idx);
    logic [47:0] sh;
    sh = TRUNK_DA << {idx, 3'b000};
    return sh[47:40];
  endfunction

endpackage

// File: rtl/fcsrw_crc_step.sv
module fcsrw_crc_step
  import fcsrw_pkg::*;
(
  input  logic [31:0] crc_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] stage [0:8];

  assign stage[0] = crc_i ^ {24'd0, byte_i};

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ CRC_POLY_REFL)
                                    : (stage[b] >> 1);
  end

  assign crc_o = stage[8];

endmodule

// File: rtl/fcsrw_crc_acc.sv
module fcsrw_crc_acc (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] fcs_o
);

  logic [31:0] crc_q, crc_nxt;

  fcsrw_crc_step u_step (
    .crc_i  (crc_q),
    .byte_i (byte_i),
    .crc_o  (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_nxt;
  end

  assign fcs_o = ~crc_q;

endmodule

// File: rtl/fcsrw_ctrl.sv
module fcsrw_ctrl
  import fcsrw_pkg::*;
#(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned ENC_HDR = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic [LEN_W-1:0] buf_addr_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  output logic             crc_init_o,
  output logic             crc_en_o,
  input  logic [31:0]      fcs_i,
  output logic             done_o
);

  localparam int unsigned INNER_START = ETH_HDR_BYTES + ENC_HDR;
  localparam int unsigned TRIM        = ENC_HDR + 4;

  rw_state_e        state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] ptr_q, ptr_d;
  logic [LEN_W-1:0] end_q, end_d;
  logic [15:0]      type_q, type_d;
  logic [2:0]       idx_q, idx_d;

  logic [15:0] inner_len;
  logic [16:0] need;
  logic        fit;

  assign inner_len = type_q - 16'(TRIM);
  assign need      = 17'(INNER_START) + {1'b0, inner_len};
  assign fit       = (type_q >= 16'(TRIM)) && (need <= 17'(len_q));

  always_comb begin
    state_d     = state_q;
    len_d       = len_q;
    ptr_d       = ptr_q;
    end_d       = end_q;
    type_d      = type_q;
    idx_d       = idx_q;
    buf_addr_o  = '0;
    buf_we_o    = 1'b0;
    buf_wdata_o = '0;
    crc_init_o  = 1'b0;
    crc_en_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        len_d      = frame_len_i;
        idx_d      = '0;
        crc_init_o = 1'b1;
        state_d    = ST_DA;
      end
      ST_DA: begin
        buf_addr_o = LEN_W'(idx_q);
        if (buf_rdata_i != da_byte(idx_q)) state_d = ST_DONE;
        else if (idx_q == 3'd5)            state_d = ST_TYPE_HI;
        else                               idx_d   = idx_q + 3'd1;
      end
      ST_TYPE_HI: begin
        buf_addr_o    = LEN_W'(12);
        type_d[15:8]  = buf_rdata_i;
        state_d       = ST_TYPE_LO;
      end
      ST_TYPE_LO: begin
        buf_addr_o    = LEN_W'(13);
        type_d[7:0]   = buf_rdata_i;
        state_d       = ST_CHECK;
      end
      ST_CHECK: begin
        if (fit) begin
          ptr_d   = LEN_W'(INNER_START);
          end_d   = LEN_W'(need);
          state_d = ST_PATCH;
        end else begin
          state_d = ST_DONE;
        end
      end
      ST_PATCH: begin
        buf_addr_o  = LEN_W'(4);
        buf_we_o    = 1'b1;
        buf_wdata_o = 8'h00;
        idx_d       = '0;
        state_d     = (ptr_q == end_q) ? ST_FCS : ST_CRC;
      end
      ST_CRC: begin
        buf_addr_o = ptr_q;
        crc_en_o   = 1'b1;
        ptr_d      = ptr_q + LEN_W'(1);
        if (ptr_d == end_q) state_d = ST_FCS;
      end
      ST_FCS: begin
        buf_addr_o  = len_q - LEN_W'(4) + LEN_W'(idx_q);
        buf_we_o    = 1'b1;
        buf_wdata_o = fcs_i[{idx_q[1:0], 3'b000} +: 8];
        if (idx_q == 3'd3) state_d = ST_DONE;
        else               idx_d   = idx_q + 3'd1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      ptr_q   <= '0;
      end_q   <= '0;
      type_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      ptr_q   <= ptr_d;
      end_q   <= end_d;
      type_q  <= type_d;
      idx_q   <= idx_d;
    end
  end

  assign done_o = (state_q == ST_DONE);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_len_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (len_q == $past(len_q)));

  assert_write_place_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (buf_addr_o == LEN_W'(4)) ||
                 (({1'b0, buf_addr_o} + (LEN_W+1)'(4) >= {1'b0, len_q}) &&
                  (buf_addr_o < len_q)));

  assert_patch_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && buf_addr_o == LEN_W'(4)) |-> (buf_wdata_o == 8'h00));

  assert_crc_span_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_en_o |-> (buf_addr_o >= LEN_W'(INNER_START)) && (buf_addr_o < len_q));

endmodule

// File: rtl/fcs_rewriter.sv
module fcs_rewriter #(
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned ENC_HDR = 26
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  output logic [LEN_W-1:0] buf_addr_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o,
  output logic             done_o
);

  logic        crc_init, crc_en;
  logic [31:0] fcs;

  fcsrw_ctrl #(
    .LEN_W   (LEN_W),
    .ENC_HDR (ENC_HDR)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .frame_len_i (frame_len_i),
    .buf_addr_o  (buf_addr_o),
    .buf_rdata_i (buf_rdata_i),
    .buf_we_o    (buf_we_o),
    .buf_wdata_o (buf_wdata_o),
    .crc_init_o  (crc_init),
    .crc_en_o    (crc_en),
    .fcs_i       (fcs),
    .done_o      (done_o)
  );

  fcsrw_crc_acc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .en_i   (crc_en),
    .byte_i (buf_rdata_i),
    .fcs_o  (fcs)
  );

  assert_we_not_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !buf_we_o);

endmodule

// File: tb/fcs_rewriter_tb_top.sv
module fcs_rewriter_tb_top;

  localparam int LW    = 9;
  localparam int DEPTH = 1 << LW;
  localparam int HDR   = 26;
  localparam int START = 14 + HDR;
  localparam int NV    = 10;

  // tot, type, corrupted DA byte (-1 none), fill seed
  localparam int V_TOT [NV]  = '{64, 100, 64, 64, 80, 80, 80, 80, 511, 200};
  localparam int V_TYP [NV]  = '{54, 30, 55, 29, 40, 54, 54, 54, 500, 33024};
  localparam int V_BAD [NV]  = '{-1, -1, -1, -1, -1, 0, 5, 4, -1, -1};
  localparam int V_SEED [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] flen = '0;
  logic [LW-1:0] baddr;
  logic [7:0]    brdata, bwdata;
  logic          bwe, done;

  logic [7:0] img [0:DEPTH-1];
  logic [7:0] expv [0:DEPTH-1];
  logic [7:0] wr_mem [0:DEPTH-1];
  int         wr_gen [0:DEPTH-1];
  int         gen = 1;
  int         total = 0;
  int         bad = 0;
  logic [31:0] exp_fcs;

  always #5 clk = ~clk;

  fcs_rewriter #(.LEN_W(LW), .ENC_HDR(HDR)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .frame_len_i (flen),
    .buf_addr_o  (baddr),
    .buf_rdata_i (brdata),
    .buf_we_o    (bwe),
    .buf_wdata_o (bwdata),
    .done_o      (done)
  );

  always @(posedge clk) if (bwe) begin
    wr_mem[baddr] <= bwdata;
    wr_gen[baddr] <= gen;
  end

  assign brdata = (wr_gen[baddr] == gen) ? wr_mem[baddr] : img[baddr];

  function automatic logic [7:0] buf_at(int a);
    return (wr_gen[a] == gen) ? wr_mem[a] : img[a];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expd);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expd);
    end
  endtask

  // builds the buffer and the expected image from the requirements
  task automatic build(int tot, int typ, int badb, int seed, output bit hit, output bit fit);
    logic [7:0] da [6] = '{8'h01, 8'h00, 8'h0C, 8'h00, 8'h10, 8'h00};
    logic [31:0] c;
    int n;
    gen++;
    for (int i = 0; i < DEPTH; i++) img[i] = 8'((i * 29 + seed * 7) & 255);
    for (int i = 0; i < 6; i++) img[i] = da[i];
    if (badb >= 0) img[badb] ^= 8'h5A;
    img[12] = 8'(typ >> 8);
    img[13] = 8'(typ & 255);
    for (int i = 0; i < DEPTH; i++) expv[i] = img[i];
    hit = (badb < 0);
    n   = typ - (HDR + 4);
    fit = (typ >= HDR + 4) && (START + n <= tot);
    exp_fcs = '0;
    if (hit && fit) begin
      expv[4] = 8'h00;
      c = 32'hFFFF_FFFF;
      for (int i = START; i < START + n; i++) begin
        c ^= {24'd0, expv[i]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      exp_fcs = ~c;
      for (int k = 0; k < 4; k++) expv[tot - 4 + k] = exp_fcs[8*k +: 8];
    end
  endtask

  task automatic run(int tot, string req);
    int w = 0;
    @(negedge clk);
    flen  = LW'(tot);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && w < 2000) begin @(negedge clk); w++; end
    check(done, "R8", "done seen", int'(done), 1);
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
  endtask

  task automatic compare_all(string req);
    int first = -1;
    for (int i = 0; i < DEPTH; i++) if (buf_at(i) !== expv[i] && first < 0) first = i;
    if (first < 0) check(1'b1, req, "image", 0, 0);
    else check(1'b0, req, $sformatf("image byte %0d", first), int'(buf_at(first)), int'(expv[first]));
  endtask

  initial begin
    bit hit, fit;
    int dn;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !bwe, "R1", "outputs in reset", {done, bwe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !bwe, "R1", "outputs after reset", {done, bwe}, 0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      build(V_TOT[v], V_TYP[v], V_BAD[v], V_SEED[v], hit, fit);
      if (!hit)                    tag = "R2";
      else if (!fit)               tag = "R5";
      else if (V_TYP[v] == HDR + 4) tag = "R10";
      else                         tag = "R4";
      run(V_TOT[v], tag);
      compare_all(tag);
      if (hit && fit) begin
        check(buf_at(4) == 8'h00, "R3", "DA byte 4", int'(buf_at(4)), 0);
        check({buf_at(V_TOT[v]-1), buf_at(V_TOT[v]-2), buf_at(V_TOT[v]-3), buf_at(V_TOT[v]-4)} == exp_fcs,
              "R7", "stored FCS",
              int'({buf_at(V_TOT[v]-1), buf_at(V_TOT[v]-2), buf_at(V_TOT[v]-3), buf_at(V_TOT[v]-4)}),
              int'(exp_fcs));
      end
    end

    // R6: known CRC-32 check value over ASCII "123456789"
    build(53, HDR + 4 + 9, -1, 11, hit, fit);
    for (int i = 0; i < 9; i++) begin img[START + i] = 8'(8'h31 + i); expv[START + i] = 8'(8'h31 + i); end
    for (int k = 0; k < 4; k++) expv[49 + k] = 8'((32'hCBF4_3926 >> (8*k)) & 255);
    run(53, "R6");
    check({buf_at(52), buf_at(51), buf_at(50), buf_at(49)} == 32'hCBF4_3926, "R6", "check value",
          int'({buf_at(52), buf_at(51), buf_at(50), buf_at(49)}), 32'hCBF4_3926);
    compare_all("R6");

    // R9: start while busy is ignored
    build(64, 54, -1, 12, hit, fit);
    @(negedge clk);
    flen = LW'(64); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    flen = LW'(100); start = 1'b1;
    @(negedge clk);
    start = 1'b0; flen = '0;
    dn = 0;
    for (int c = 0; c < 300; c++) begin if (done) dn++; @(negedge clk); end
    check(dn == 1, "R9", "done count", dn, 1);
    compare_all("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule